// File: doc/BRIEF.md
# Address Window Guard with Privilege Mode Control

This block stands between a processor's address path and memory. For each access it checks the issued address against a lower limit register and an upper limit register, and reports in the same cycle whether the access may proceed. An input selects one of two checks. In window mode the address itself must lie between the two limits, with both ends allowed. In offset mode the address is an unsigned displacement added to the lower limit, and the sum must not pass the upper limit.

The block also holds the privilege state: a single bit that selects supervisor or user. Only supervisor code may change the limit registers, the privilege bit or the fault-enable bit. Code in either mode can read all of them. A user write is dropped and raises a privilege fault. A service-call strobe saves the current program counter and the prior mode on a small stack, enters supervisor mode and redirects to a fixed entry address. A return strobe pops the stack, restores the saved mode and redirects to the saved program counter.

Top module: `bbp_unit`

## Requirements
- R1: After reset the unit is in supervisor mode (`mode_sup`=1), the fault enable is 0, the lower limit is 0, the upper limit is all ones, the call stack is empty and `saved_pc` reads 0.
- R2: With `reloc_mode`=0, an access is legal exactly when lower ≤ `acc_addr` ≤ upper, and both bounds count as inside.
- R3: With `reloc_mode`=1, an access is legal exactly when the unsigned sum lower + `acc_addr` ≤ upper.
- R4: In offset mode a carry out of the sum makes the access illegal, whatever the upper limit holds.
- R5: `acc_ok` and `prot_fault` are combinational in the request cycle. `acc_ok`=`acc_valid`&legal. `prot_fault`=`acc_valid`&!legal&fault-enable, so no fault is raised while the enable is 0.
- R6: A supervisor write (`wr_en`, `wr_sel`: 0 lower limit, 1 upper limit, 2 mode with `wr_data[0]`=1 meaning supervisor, 3 fault enable in `wr_data[0]`) takes effect from the next cycle. `rd_data` returns the field chosen by `rd_sel` with the same encoding, in either mode.
- R7: A write in user mode changes no state and drives `priv_fault` high for exactly the next cycle. User mode is left only through a service call or a return.
- R8: A `sys_call` with room on the stack pushes `cur_pc` and the prior mode. In the next cycle it gives `mode_sup`=1, `saved_pc`=`cur_pc`, and a one-cycle `redir_valid` with `redir_pc`=ENTRY_PC (default 0x100).
- R9: A `sys_ret` on a non-empty stack pops one entry. In the next cycle it restores that entry's mode and drives `redir_valid` with `redir_pc` equal to the popped PC. `saved_pc` then shows the new top entry, or 0 when the stack is empty. Nested calls unwind in reverse order.
- R10: A `sys_ret` on an empty stack and a `sys_call` on a full stack (NEST_D entries, default 4) are ignored: no redirect and no state change. When both strobes come in one cycle, the call is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | Access request strobe |
| acc_addr | input | AW | Access address or displacement |
| reloc_mode | input | 1 | 0 window check, 1 offset check |
| wr_en | input | 1 | Protected-state write strobe |
| wr_sel | input | 2 | Field to write |
| wr_data | input | AW | Write value |
| rd_sel | input | 2 | Field to read |
| rd_data | output | AW | Read value of the selected field |
| sys_call | input | 1 | Service-call strobe |
| sys_ret | input | 1 | Return strobe |
| cur_pc | input | PW | Current program counter |
| acc_ok | output | 1 | Access permitted |
| prot_fault | output | 1 | Range fault |
| priv_fault | output | 1 | Rejected user write pulse |
| mode_sup | output | 1 | 1 supervisor, 0 user |
| saved_pc | output | PW | PC at the top of the call stack |
| redir_valid | output | 1 | Redirect pulse |
| redir_pc | output | PW | Redirect target |

## Verification
The bound checker covers, on every cycle, the rules that hold for any sequence of inputs. `acc_ok` and `prot_fault` are never high together. A fault needs a request. A carry out in offset mode never yields permission. A privilege fault always follows a user write. User mode is never left without a call or a return. Every redirect has a cause, and a service-call redirect lands in supervisor mode at the entry address. The scenarios in the bench are needed for the rest: exact inclusive edges of each check, the reset values, write-then-read of each field, restoration of the right mode and PC through nested calls, and the ignored empty-stack return, full-stack call and simultaneous call and return.

// File: rtl/bbp_pkg.sv
package bbp_pkg;
  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_MODE = 2'd2,
    SEL_EXC  = 2'd3
  } bbp_sel_e;

  typedef enum logic {
    PRIV_USER = 1'b0,
    PRIV_SUP  = 1'b1
  } bbp_priv_e;
endpackage

// File: rtl/bbp_range_chk.sv
module bbp_range_chk #(
  parameter int AW = 32
) (
  input  logic          reloc,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] addr,
  output logic          legal
);
  logic [AW:0] sum_ext;
  logic        win_ok;
  logic        off_ok;

  always_comb begin
    sum_ext = {1'b0, lo} + {1'b0, addr};
    win_ok  = (addr >= lo) && (addr <= hi);
    off_ok  = !sum_ext[AW] && (sum_ext[AW-1:0] <= hi);
    legal   = reloc ? off_ok : win_ok;
  end
endmodule

// File: rtl/bbp_prot_regs.sv
module bbp_prot_regs
  import bbp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          is_sup,
  output logic [AW-1:0] lo_q,
  output logic [AW-1:0] hi_q,
  output logic          exc_q,
  output logic          mode_wr,
  output logic          mode_wr_val,
  output logic          priv_fault
);
  logic          wr_ok;
  logic          lo_en, hi_en, exc_en;
  logic          pf_d;
  bbp_sel_e      sel;

  always_comb begin
    sel         = bbp_sel_e'(wr_sel);
    wr_ok       = wr_en && is_sup;
    lo_en       = wr_ok && (sel == SEL_LO);
    hi_en       = wr_ok && (sel == SEL_HI);
    exc_en      = wr_ok && (sel == SEL_EXC);
    mode_wr     = wr_ok && (sel == SEL_MODE);
    mode_wr_val = wr_data[0];
    pf_d        = wr_en && !is_sup;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q       <= '0;
      hi_q       <= '1;
      exc_q      <= 1'b0;
      priv_fault <= 1'b0;
    end else begin
      if (lo_en)  lo_q  <= wr_data;
      if (hi_en)  hi_q  <= wr_data;
      if (exc_en) exc_q <= wr_data[0];
      priv_fault <= pf_d;
    end
  end
endmodule

// File: rtl/bbp_mode_ctl.sv
module bbp_mode_ctl
  import bbp_pkg::*;
#(
  parameter int          PW       = 32,
  parameter int          NEST_D   = 4,
  parameter logic [PW-1:0] ENTRY_PC = 'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_call,
  input  logic          sys_ret,
  input  logic [PW-1:0] cur_pc,
  input  logic          mode_wr,
  input  logic          mode_wr_val,
  output logic          mode_sup,
  output logic [PW-1:0] saved_pc,
  output logic          redir_valid,
  output logic [PW-1:0] redir_pc
);
  localparam int DW = $clog2(NEST_D + 1);
  localparam int IW = (NEST_D > 1) ? $clog2(NEST_D) : 1;

  bbp_priv_e       mode_q, mode_d;
  logic [DW-1:0]   depth_q, depth_d;
  logic [PW-1:0]   pc_stk  [NEST_D];
  logic            md_stk  [NEST_D];
  logic [IW-1:0]   top_idx, push_idx;
  logic            do_push, do_pop;
  logic            rv_d;
  logic [PW-1:0]   rp_d;

  always_comb begin
    top_idx  = IW'(depth_q - 1'b1);
    push_idx = IW'(depth_q);
    do_push  = sys_call && (depth_q < DW'(NEST_D));
    do_pop   = sys_ret && !sys_call && (depth_q != '0);
    mode_d   = mode_q;
    depth_d  = depth_q;
    rv_d     = 1'b0;
    rp_d     = redir_pc;
    if (do_push) begin
      mode_d  = PRIV_SUP;
      depth_d = depth_q + 1'b1;
      rv_d    = 1'b1;
      rp_d    = ENTRY_PC;
    end else if (do_pop) begin
      mode_d  = bbp_priv_e'(md_stk[top_idx]);
      depth_d = depth_q - 1'b1;
      rv_d    = 1'b1;
      rp_d    = pc_stk[top_idx];
    end else if (mode_wr) begin
      mode_d  = bbp_priv_e'(mode_wr_val);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= PRIV_SUP;
      depth_q     <= '0;
      redir_valid <= 1'b0;
      redir_pc    <= '0;
    end else begin
      mode_q      <= mode_d;
      depth_q     <= depth_d;
      redir_valid <= rv_d;
      redir_pc    <= rp_d;
    end
  end

  for (genvar g = 0; g < NEST_D; g++) begin : g_stk
    logic slot_en;
    assign slot_en = do_push && (push_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_stk[g] <= '0;
        md_stk[g] <= 1'b0;
      end else if (slot_en) begin
        pc_stk[g] <= cur_pc;
        md_stk[g] <= mode_q;
      end
    end
  end

  always_comb begin
    mode_sup = (mode_q == PRIV_SUP);
    saved_pc = (depth_q == '0) ? '0 : pc_stk[top_idx];
  end
endmodule

// File: rtl/bbp_unit.sv
module bbp_unit
  import bbp_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            PW       = 32,
  parameter int            NEST_D   = 4,
  parameter logic [PW-1:0] ENTRY_PC = 'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          reloc_mode,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [AW-1:0] rd_data,
  input  logic          sys_call,
  input  logic          sys_ret,
  input  logic [PW-1:0] cur_pc,
  output logic          acc_ok,
  output logic          prot_fault,
  output logic          priv_fault,
  output logic          mode_sup,
  output logic [PW-1:0] saved_pc,
  output logic          redir_valid,
  output logic [PW-1:0] redir_pc
);
  logic [1:0]    rst_sync_q;
  logic          rst_ni;
  logic [AW-1:0] lo_q, hi_q;
  logic          exc_q;
  logic          mode_wr, mode_wr_val;
  logic          legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  bbp_prot_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_ni), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .is_sup(mode_sup), .lo_q(lo_q), .hi_q(hi_q),
    .exc_q(exc_q), .mode_wr(mode_wr), .mode_wr_val(mode_wr_val),
    .priv_fault(priv_fault)
  );

  bbp_range_chk #(.AW(AW)) u_chk_rng (
    .reloc(reloc_mode), .lo(lo_q), .hi(hi_q), .addr(acc_addr), .legal(legal)
  );

  bbp_mode_ctl #(.PW(PW), .NEST_D(NEST_D), .ENTRY_PC(ENTRY_PC)) u_mode (
    .clk(clk), .rst_n(rst_ni), .sys_call(sys_call), .sys_ret(sys_ret),
    .cur_pc(cur_pc), .mode_wr(mode_wr), .mode_wr_val(mode_wr_val),
    .mode_sup(mode_sup), .saved_pc(saved_pc), .redir_valid(redir_valid),
    .redir_pc(redir_pc)
  );

  always_comb begin
    acc_ok     = acc_valid && legal;
    prot_fault = acc_valid && !legal && exc_q;
    unique case (bbp_sel_e'(rd_sel))
      SEL_LO:   rd_data = lo_q;
      SEL_HI:   rd_data = hi_q;
      SEL_MODE: rd_data = AW'(mode_sup);
      default:  rd_data = AW'(exc_q);
    endcase
  end
endmodule

// File: rtl/bbp_unit_chk.sv
module bbp_unit_chk #(
  parameter int            AW       = 32,
  parameter int            PW       = 32,
  parameter logic [PW-1:0] ENTRY_PC = 'h100
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          acc_valid,
  input logic [AW-1:0] acc_addr,
  input logic          reloc_mode,
  input logic [AW-1:0] lo_q,
  input logic          wr_en,
  input logic          sys_call,
  input logic          sys_ret,
  input logic          acc_ok,
  input logic          prot_fault,
  input logic          priv_fault,
  input logic          mode_sup,
  input logic          redir_valid,
  input logic [PW-1:0] redir_pc
);
  logic [AW:0] chk_sum;
  assign chk_sum = {1'b0, lo_q} + {1'b0, acc_addr};

  assert_ok_fault_excl_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    !(acc_ok && prot_fault));
  assert_fault_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    prot_fault |-> acc_valid);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc_valid && reloc_mode && chk_sum[AW]) |-> !acc_ok);
  assert_priv_cause_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    priv_fault |-> $past(wr_en && !mode_sup));
  assert_user_sticky_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(!mode_sup) && !$past(sys_call) && !$past(sys_ret)) |-> !mode_sup);
  assert_redir_cause_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    redir_valid |-> $past(sys_call || sys_ret));
  assert_call_entry_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (redir_valid && $past(sys_call)) |-> (mode_sup && redir_pc == ENTRY_PC));
endmodule

bind bbp_unit bbp_unit_chk #(.AW(AW), .PW(PW), .ENTRY_PC(ENTRY_PC)) u_bbp_chk (
  .clk(clk), .rst_ni(rst_ni), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .reloc_mode(reloc_mode), .lo_q(lo_q), .wr_en(wr_en), .sys_call(sys_call),
  .sys_ret(sys_ret), .acc_ok(acc_ok), .prot_fault(prot_fault),
  .priv_fault(priv_fault), .mode_sup(mode_sup), .redir_valid(redir_valid),
  .redir_pc(redir_pc)
);

// File: tb/tb_bbp_unit.sv
`timescale 1ns/1ps
module tb_bbp_unit;
  localparam int AW = 32;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic acc_valid, reloc_mode, wr_en, sys_call, sys_ret;
  logic [AW-1:0] acc_addr, wr_data, rd_data;
  logic [1:0] wr_sel, rd_sel;
  logic [PW-1:0] cur_pc, saved_pc, redir_pc;
  logic acc_ok, prot_fault, priv_fault, mode_sup, redir_valid;

  bbp_unit dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .reloc_mode(reloc_mode), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .sys_call(sys_call), .sys_ret(sys_ret),
    .cur_pc(cur_pc), .acc_ok(acc_ok), .prot_fault(prot_fault),
    .priv_fault(priv_fault), .mode_sup(mode_sup), .saved_pc(saved_pc),
    .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  always #2 clk = ~clk;

  typedef struct {
    int          cyc;
    int          sel;
    logic [63:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] actual(int sel);
    case (sel)
      0: return 64'(acc_ok);
      1: return 64'(prot_fault);
      2: return 64'(priv_fault);
      3: return 64'(mode_sup);
      4: return 64'(saved_pc);
      5: return 64'(redir_valid);
      6: return 64'(redir_pc);
      default: return 64'(rd_data);
    endcase
  endfunction

  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (actual(it.sel) !== it.exp) begin
        errors++;
        $display("FAIL %s sel%0d actual %h expected %h", it.req, it.sel,
                 actual(it.sel), it.exp);
      end
    end
  end

  task automatic expect_at(int dly, int sel, logic [63:0] exp, string req);
    item_t it;
    it.cyc = cyc + dly; it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 0; wr_en = 0; sys_call = 0; sys_ret = 0;
  endtask

  task automatic wr(logic [1:0] s, logic [AW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    idle();
  endtask

  task automatic rd(logic [1:0] s, logic [AW-1:0] exp, string req);
    @(negedge clk);
    rd_sel = s;
    expect_at(0, 7, 64'(exp), req);
  endtask

  task automatic acc(logic rel, logic [AW-1:0] a, logic ok, logic flt, string req);
    @(negedge clk);
    acc_valid = 1; reloc_mode = rel; acc_addr = a;
    expect_at(0, 0, 64'(ok), req);
    expect_at(0, 1, 64'(flt), req);
    idle();
  endtask

  task automatic call(logic [PW-1:0] pc, logic also_ret, logic taken);
    @(negedge clk);
    sys_call = 1; sys_ret = also_ret; cur_pc = pc;
    expect_at(1, 5, 64'(taken), "R8 redirect");
    if (taken) begin
      expect_at(1, 3, 64'd1, "R8 mode");
      expect_at(1, 4, 64'(pc), "R8 saved_pc");
      expect_at(1, 6, 64'h100, "R8 entry");
    end
    idle();
  endtask

  task automatic ret(logic taken, logic exp_mode, logic [PW-1:0] exp_pc, string req);
    @(negedge clk);
    sys_ret = 1;
    expect_at(1, 5, 64'(taken), req);
    expect_at(1, 3, 64'(exp_mode), req);
    if (taken) expect_at(1, 6, 64'(exp_pc), req);
    idle();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; acc_valid = 0; reloc_mode = 0; wr_en = 0; sys_call = 0;
    sys_ret = 0; acc_addr = '0; wr_data = '0; wr_sel = '0; rd_sel = '0; cur_pc = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    expect_at(0, 3, 64'd1, "R1 mode");
    expect_at(0, 4, 64'd0, "R1 saved_pc");
    rd(2'd0, 32'h0, "R1 lo");
    rd(2'd1, 32'hFFFF_FFFF, "R1 hi");
    rd(2'd3, 32'h0, "R1 exc");
    acc(1'b0, 32'h1234_5678, 1'b1, 1'b0, "R1 open window");
    // R6 supervisor writes
    wr(2'd0, 32'h1000);
    wr(2'd1, 32'h1FFF);
    wr(2'd3, 32'h1);
    rd(2'd0, 32'h1000, "R6 lo");
    rd(2'd1, 32'h1FFF, "R6 hi");
    rd(2'd3, 32'h1, "R6 exc");
    // R2 window edges
    acc(1'b0, 32'h0FFF, 1'b0, 1'b1, "R2 below");
    acc(1'b0, 32'h1000, 1'b1, 1'b0, "R2 low edge");
    acc(1'b0, 32'h1FFF, 1'b1, 1'b0, "R2 high edge");
    acc(1'b0, 32'h2000, 1'b0, 1'b1, "R2 above");
    // R3 offset check
    acc(1'b1, 32'h0FFF, 1'b1, 1'b0, "R3 edge");
    acc(1'b1, 32'h1000, 1'b0, 1'b1, "R3 past");
    acc(1'b1, 32'h0, 1'b1, 1'b0, "R3 zero");
    // R4 carry out
    wr(2'd0, 32'hFFFF_F000);
    wr(2'd1, 32'hFFFF_FFFF);
    acc(1'b1, 32'h1000, 1'b0, 1'b1, "R4 carry");
    acc(1'b1, 32'h0FFF, 1'b1, 1'b0, "R4 no carry");
    wr(2'd0, 32'h1000);
    wr(2'd1, 32'h1FFF);
    // R5 fault gated by enable
    wr(2'd3, 32'h0);
    acc(1'b0, 32'h3000, 1'b0, 1'b0, "R5 disabled");
    wr(2'd3, 32'h1);
    acc(1'b0, 32'h3000, 1'b0, 1'b1, "R5 enabled");
    // R8 call from supervisor
    call(32'h4444, 1'b0, 1'b1);
    @(negedge clk);
    expect_at(0, 5, 64'd0, "R8 pulse ends");
    // enter user mode
    wr(2'd2, 32'h0);
    expect_at(0, 3, 64'd0, "R6 mode write");
    rd(2'd2, 32'h0, "R6 mode read");
    // R7 user writes rejected
    @(negedge clk);
    wr_en = 1; wr_sel = 2'd0; wr_data = 32'hDEAD;
    expect_at(1, 2, 64'd1, "R7 pulse");
    expect_at(2, 2, 64'd0, "R7 pulse ends");
    idle();
    @(negedge clk);
    rd(2'd0, 32'h1000, "R7 lo kept");
    wr(2'd2, 32'h1);
    expect_at(0, 3, 64'd0, "R7 mode kept");
    wr(2'd3, 32'h0);
    rd(2'd3, 32'h1, "R7 exc kept");
    // R8/R9 nested
    call(32'h5550, 1'b0, 1'b1);
    ret(1'b1, 1'b0, 32'h5550, "R9 back to user");
    expect_at(1, 4, 64'h4444, "R9 top after pop");
    ret(1'b1, 1'b1, 32'h4444, "R9 outer frame");
    expect_at(1, 4, 64'h0, "R9 empty saved_pc");
    // R10 empty return
    ret(1'b0, 1'b1, 32'h0, "R10 empty return");
    // R10 call wins over return
    call(32'h7000, 1'b1, 1'b1);
    call(32'h7004, 1'b0, 1'b1);
    call(32'h7008, 1'b0, 1'b1);
    call(32'h700C, 1'b0, 1'b1);
    call(32'h7010, 1'b0, 1'b0);
    expect_at(1, 4, 64'h700C, "R10 full call ignored");
    ret(1'b1, 1'b1, 32'h700C, "R10 top intact");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule